// File: doc/BRIEF.md
# Sequential Byte-Sliced Multiplier

This block forms the full-width product of two operands with one narrow unsigned multiplier that it reuses over several clock cycles. Each operand splits into a low and a high slice. The four slice-by-slice partial products are formed one per cycle and merged into a result register made of four slice-wide lanes. With the default slice width of 8, the operands are 16 bits and the product is 32 bits.

A mode bit selects unsigned or two's-complement arithmetic. In two's-complement mode, two correction cycles follow the unsigned merge. Each correction removes one operand from the upper half of the result when the other operand's sign bit is set. A caller pulses `start` with both operands and the mode bit. It then waits for the one-cycle `done` pulse and reads `result`, which holds its value until the next accepted start.

Top module: `byteslice_mul`

## Requirements
- R1: While `rst` is high at a clock edge, `result` clears to 0 and `busy` and `done` clear to 0 after that edge.
- R2: A `start` seen at an edge while `busy` is low captures `opa`, `opb` and `signed_mode`, and `busy` is high in the following cycle.
- R3: A `start` seen while `busy` is high is ignored: the running operation finishes with its own captured operands and mode, and its timing is unchanged.
- R4: With `signed_mode` = 0, the final `result` equals opa × opb as unsigned integers.
- R5: With `signed_mode` = 1, the final `result` equals opa × opb as two's-complement integers, written as a 32-bit two's-complement value.
- R6: One cycle after the accepting edge (first step), result[15:0] holds opa[7:0]×opb[7:0]. One cycle later (second step), result[31:16] holds opa[15:8]×opb[15:8] and result[15:0] is unchanged.
- R7: The third and fourth steps add opa[7:0]×opb[15:8] and then opa[15:8]×opb[7:0], each shifted left by 8, into result. The carries propagate up to bit 31.
- R8: In signed mode, the fifth step subtracts opa from result[31:16] when opb[15] is 1 and otherwise leaves result unchanged. The sixth step does the same with opb when opa[15] is 1.
- R9: `busy` stays high for exactly 4 cycles in unsigned mode and 6 in signed mode. `done` is high for exactly the one cycle after `busy` falls.
- R10: While `busy` is low and no start is accepted, `result` does not change, whatever `opa`, `opb` and `signed_mode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (acted on only when idle) |
| signed_mode | input | 1 | 1 = two's-complement, 0 = unsigned |
| opa | input | 2*SLICE_W | First operand |
| opb | input | 2*SLICE_W | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| result | output | 4*SLICE_W | Product register |

## Verification
The bench builds the block with SLICE_W = 8, which gives the 16 × 16 form. At this width the corner operands 0, 0xFFFF, 0x8000 and 0x7FFF exercise every sign-bit combination and a carry out of every result lane. Because the model is compared on every clock, the intermediate lane values after each step can be checked, including the skipped corrections when a sign bit is clear. Random operand pairs in both modes, ignored starts during an operation, and operand changes while idle cover the handshake rules.

// File: rtl/byteslice_mul_pkg.sv
package byteslice_mul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL,
        ST_HH,
        ST_LH,
        ST_HL,
        ST_FIXB,
        ST_FIXA
    } step_e;

    typedef enum logic [2:0] {
        ACC_HOLD,
        ACC_PUT_LO,
        ACC_PUT_HI,
        ACC_ADD_MID,
        ACC_SUB_HI
    } acc_op_e;

    function automatic step_e step_after(step_e s, logic sgn);
        case (s)
            ST_LL:   return ST_HH;
            ST_HH:   return ST_LH;
            ST_LH:   return ST_HL;
            ST_HL:   return sgn ? ST_FIXB : ST_IDLE;
            ST_FIXB: return ST_FIXA;
            default: return ST_IDLE;
        endcase
    endfunction

    function automatic logic is_final(step_e s, logic sgn);
        return (s != ST_IDLE) && (step_after(s, sgn) == ST_IDLE);
    endfunction

endpackage

// File: rtl/bsm_slice_mult.sv
module bsm_slice_mult #(
    parameter int SLICE_W = 8
) (
    input  logic [SLICE_W-1:0]   x,
    input  logic [SLICE_W-1:0]   y,
    output logic [2*SLICE_W-1:0] p
);
    localparam int PW = 2 * SLICE_W;

    logic [PW-1:0] rows [SLICE_W];

    for (genvar i = 0; i < SLICE_W; i++) begin : g_row
        assign rows[i] = y[i] ? ({{SLICE_W{1'b0}}, x} << i) : '0;
    end

    always_comb begin
        p = '0;
        for (int k = 0; k < SLICE_W; k++) begin
            p = p + rows[k];
        end
    end

endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
    import byteslice_mul_pkg::*;
#(
    parameter int SLICE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 signed_mode,
    input  logic [2*SLICE_W-1:0] opa,
    input  logic [2*SLICE_W-1:0] opb,
    output logic                 busy,
    output logic                 done,
    output logic [SLICE_W-1:0]   mul_x,
    output logic [SLICE_W-1:0]   mul_y,
    output acc_op_e              acc_op,
    output logic [2*SLICE_W-1:0] sub_val
);
    localparam int OW = 2 * SLICE_W;

    step_e          step_q;
    logic [OW-1:0]  a_q, b_q;
    logic           sgn_q;
    logic           accept;

    assign busy   = (step_q != ST_IDLE);
    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_IDLE;
            a_q    <= '0;
            b_q    <= '0;
            sgn_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= is_final(step_q, sgn_q);
            if (accept) begin
                a_q    <= opa;
                b_q    <= opb;
                sgn_q  <= signed_mode;
                step_q <= ST_LL;
            end else if (busy) begin
                step_q <= step_after(step_q, sgn_q);
            end
        end
    end

    always_comb begin
        mul_x   = a_q[SLICE_W-1:0];
        mul_y   = b_q[SLICE_W-1:0];
        acc_op  = ACC_HOLD;
        sub_val = '0;
        case (step_q)
            ST_LL: acc_op = ACC_PUT_LO;
            ST_HH: begin
                mul_x  = a_q[OW-1:SLICE_W];
                mul_y  = b_q[OW-1:SLICE_W];
                acc_op = ACC_PUT_HI;
            end
            ST_LH: begin
                mul_y  = b_q[OW-1:SLICE_W];
                acc_op = ACC_ADD_MID;
            end
            ST_HL: begin
                mul_x  = a_q[OW-1:SLICE_W];
                acc_op = ACC_ADD_MID;
            end
            ST_FIXB: begin
                sub_val = a_q;
                acc_op  = b_q[OW-1] ? ACC_SUB_HI : ACC_HOLD;
            end
            ST_FIXA: begin
                sub_val = b_q;
                acc_op  = a_q[OW-1] ? ACC_SUB_HI : ACC_HOLD;
            end
            default: acc_op = ACC_HOLD;
        endcase
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_ignore_start_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(a_q) && $stable(b_q) && $stable(sgn_q)));

    assert_lat_unsigned_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !sgn_q) |-> $past(accept, 5));

    assert_lat_signed_R9: assert property (@(posedge clk) disable iff (rst)
        (done && sgn_q) |-> $past(accept, 7));

endmodule

// File: rtl/bsm_accum.sv
module bsm_accum
    import byteslice_mul_pkg::*;
#(
    parameter int SLICE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  acc_op_e              acc_op,
    input  logic [2*SLICE_W-1:0] prod,
    input  logic [2*SLICE_W-1:0] sub_val,
    output logic [4*SLICE_W-1:0] res
);
    localparam int HW = 2 * SLICE_W;
    localparam int FW = 4 * SLICE_W;
    localparam int MW = 3 * SLICE_W;

    logic [MW-1:0] mid_sum;
    logic [HW-1:0] hi_diff;

    assign mid_sum = res[FW-1:SLICE_W] + {{SLICE_W{1'b0}}, prod};
    assign hi_diff = res[FW-1:HW] - sub_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            case (acc_op)
                ACC_PUT_LO:  res[HW-1:0]       <= prod;
                ACC_PUT_HI:  res[FW-1:HW]      <= prod;
                ACC_ADD_MID: res[FW-1:SLICE_W] <= mid_sum;
                ACC_SUB_HI:  res[FW-1:HW]      <= hi_diff;
                default:     res               <= res;
            endcase
        end
    end

    assert_put_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_op == ACC_PUT_HI) |=> $stable(res[HW-1:0]));

    assert_sub_keeps_lo_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_op == ACC_SUB_HI) |=> $stable(res[HW-1:0]));

endmodule

// File: rtl/byteslice_mul.sv
module byteslice_mul
    import byteslice_mul_pkg::*;
#(
    parameter int SLICE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 signed_mode,
    input  logic [2*SLICE_W-1:0] opa,
    input  logic [2*SLICE_W-1:0] opb,
    output logic                 busy,
    output logic                 done,
    output logic [4*SLICE_W-1:0] result
);
    localparam int HW = 2 * SLICE_W;

    logic [SLICE_W-1:0] mul_x, mul_y;
    logic [HW-1:0]      prod;
    logic [HW-1:0]      sub_val;
    acc_op_e            acc_op;

    bsm_ctrl #(.SLICE_W(SLICE_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .signed_mode (signed_mode),
        .opa         (opa),
        .opb         (opb),
        .busy        (busy),
        .done        (done),
        .mul_x       (mul_x),
        .mul_y       (mul_y),
        .acc_op      (acc_op),
        .sub_val     (sub_val)
    );

    bsm_slice_mult #(.SLICE_W(SLICE_W)) u_mult (
        .x (mul_x),
        .y (mul_y),
        .p (prod)
    );

    bsm_accum #(.SLICE_W(SLICE_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .acc_op  (acc_op),
        .prod    (prod),
        .sub_val (sub_val),
        .res     (result)
    );

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

// File: tb/sim_byteslice_mul.sv
module sim_byteslice_mul;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        busy, done;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    byteslice_mul #(.SLICE_W(8)) u0 (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result)
    );

    // Behavioural reference model, advanced on each rising edge
    logic [31:0] m_res;
    logic [15:0] ma, mb;
    logic        ms;
    logic        m_busy, m_done;
    int          m_step;
    int          m_last;
    logic        m_in_rst;
    logic        armed = 1'b0;

    always @(posedge clk) begin
        m_done = 1'b0;
        if (rst) begin
            m_res = '0; m_busy = 1'b0; m_step = 0; m_last = 0;
            ma = '0; mb = '0; ms = 1'b0; m_in_rst = 1'b1; armed = 1'b1;
        end else begin
            m_in_rst = 1'b0;
            m_last = 0;
            if (!m_busy && start) begin
                ma = opa; mb = opb; ms = signed_mode;
                m_busy = 1'b1; m_step = 1;
            end else if (m_busy) begin
                case (m_step)
                    1: m_res[15:0] = 16'(ma[7:0]) * 16'(mb[7:0]);
                    2: m_res[31:16] = 16'(ma[15:8]) * 16'(mb[15:8]);
                    3: m_res = m_res + ((32'(ma[7:0]) * 32'(mb[15:8])) << 8);
                    4: m_res = m_res + ((32'(ma[15:8]) * 32'(mb[7:0])) << 8);
                    5: if (mb[15]) m_res[31:16] = m_res[31:16] - ma;
                    6: if (ma[15]) m_res[31:16] = m_res[31:16] - mb;
                    default: ;
                endcase
                m_last = m_step;
                if (m_step == (ms ? 6 : 4)) begin
                    m_busy = 1'b0; m_done = 1'b1; m_step = 0;
                end else begin
                    m_step = m_step + 1;
                end
            end
        end
    end

    function automatic string res_tag(int last, logic in_rst);
        if (in_rst) return "R1";
        if (last == 1 || last == 2) return "R6";
        if (last == 3 || last == 4) return "R7";
        if (last == 5 || last == 6) return "R8";
        return "R10";
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (armed) begin
            n_tests++;
            if (result !== m_res) begin
                n_fail++;
                $display("FAIL %s result: actual %h expected %h", res_tag(m_last, m_in_rst), result, m_res);
            end
            n_tests++;
            if (busy !== m_busy || done !== m_done) begin
                n_fail++;
                $display("FAIL %s busy/done: actual %b/%b expected %b/%b",
                         m_in_rst ? "R1" : "R9", busy, done, m_busy, m_done);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic s, input logic poke);
        logic [31:0] expv;
        int guard;
        if (s) expv = 32'(longint'($signed(a)) * longint'($signed(b)));
        else   expv = 32'(longint'(a) * longint'(b));
        @(negedge clk);
        start = 1'b1; opa = a; opb = b; signed_mode = s;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after accepted start", 32'(busy), 32'd1);
        if (poke) begin
            start = 1'b1; opa = ~a; opb = b ^ 16'h5a5a; signed_mode = ~s;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done !== 1'b1 && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        if (poke) check("R3 ignored start", result, expv);
        else if (s) check("R5 signed product", result, expv);
        else check("R4 unsigned product", result, expv);
        if (!s && a == 16'hffff && b == 16'hffff)
            check("R7 full carry", result, 32'hfffe0001);
        // idle: operand and mode changes must not move the result (R10)
        opa = 16'($urandom); opb = 16'($urandom); signed_mode = ~s;
        @(negedge clk);
        check("R10 idle hold", result, expv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] corners [4];
        corners[0] = 16'h0000; corners[1] = 16'hffff;
        corners[2] = 16'h8000; corners[3] = 16'h7fff;
        repeat (3) @(negedge clk);
        check("R1 reset result", result, 32'd0);
        check("R1 reset busy", 32'(busy), 32'd0);
        check("R1 reset done", 32'(done), 32'd0);
        rst = 1'b0;
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    run_op(corners[i], corners[j], m[0], 1'b0);
        for (int k = 0; k < 40; k++)
            run_op(16'($urandom), 16'($urandom), k[0], k % 5 == 2);
        run_op(16'h8000, 16'h8000, 1'b1, 1'b1);
        run_op(16'h1234, 16'hfedc, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule